// File: doc/BRIEF.md
# Coprocessor Compare Flag Generator

This block holds a small register file of wide coprocessor registers and, on request, compares two of them and hands the host core a 32-bit status word carrying the four condition flags negative, zero, carry and overflow. The host core names the two registers with 4-bit indices and picks one of three interpretations of their contents. The first is a signed 32-bit integer taken from the lower half of each register. The second is a signed 64-bit integer taken from the whole register. The third is a single-precision float taken from the upper half of each register.

The host core fills the register file through a simple write port. A compare request is a one-cycle strobe. The flag word appears on a registered output one clock later, together with a one-cycle valid pulse, and it stays on the output until the next request. In the integer modes the flags describe the subtraction a−b, with carry meaning "no borrow". In float mode carry means "a is greater than b" and overflow is never set.

Top module: `cmpflag_top`

## Requirements
- R1: The result word places N at bit 31, Z at bit 30, C at bit 29 and V at bit 28; bits 27 down to 0 are always zero.
- R2: When both indices name the same register in an integer mode, the flag nibble is N=0, Z=1, C=1, V=0.
- R3: Mode code 0 compares the lower 32 bits of each register as signed integers: Z is set when a−b is zero and N when a−b is negative.
- R4: Mode code 1 compares the full 64-bit registers as signed integers, with the same Z and N rules as R3.
- R5: In both integer modes V is set exactly when the signed subtraction a−b overflows the operand width.
- R6: In both integer modes C is set exactly when a is greater than or equal to b taken as unsigned numbers, so Z implies C.
- R7: Mode code 2 compares the upper 32 bits of each register as IEEE single-precision values: Z for a equal to b, N for a less than b, C for a greater than b, V always 0; at most one of N, Z, C is set.
- R8: In mode code 2, +0 and −0 compare equal, and infinities order below and above every finite value.
- R9: In mode code 2, when either operand is a NaN all four flags are 0.
- R10: Mode code 3 is reserved and returns an all-zero word, still with a valid pulse.
- R11: res_valid is high exactly in the cycle after a cycle with cmp_valid high; between requests res_flags keeps its last value.
- R12: A write with wr_en high updates the whole 64-bit register at the clock edge; a compare requested in the same cycle as a write to one of its operands sees the old contents, and a compare requested one cycle later sees the new contents.
- R13: A synchronous reset drives res_valid and res_flags to zero and overrides a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register file write enable |
| wr_idx | input | 4 | Register to write |
| wr_data | input | 64 | Data written to the whole register |
| cmp_valid | input | 1 | Compare request strobe |
| cmp_mode | input | 2 | 0 int32, 1 int64, 2 float32, 3 reserved |
| idx_a | input | 4 | Index of operand a |
| idx_b | input | 4 | Index of operand b |
| res_valid | output | 1 | Pulses one cycle after a request |
| res_flags | output | 32 | Flag word N31 Z30 C29 V28 |

## Verification
The two functions that can share a cycle are a register write and a compare that reads the register being written. The bench provokes this directly by writing a new value into an operand register while requesting a compare of that register, and then repeating the compare on the next cycle; the reference model resolves the request against its copy of the register file before applying the write, so the first result must reflect the old contents and the second the new. The random phase keeps writes and compares colliding on random indices throughout, and every cycle the registered outputs are compared against the model.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

  typedef enum logic [1:0] {
    MODE_I32 = 2'd0,
    MODE_I64 = 2'd1,
    MODE_F32 = 2'd2,
    MODE_RSV = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int FLAG_WORD_W = 32;
  localparam int FLAG_LSB    = 28;

  function automatic logic [FLAG_WORD_W-1:0] pack_flags(input nzcv_t f);
    logic [FLAG_WORD_W-1:0] w;
    w = '0;
    w[FLAG_LSB+3:FLAG_LSB] = {f.n, f.z, f.c, f.v};
    return w;
  endfunction

endpackage

// File: rtl/cmpflag_regfile.sv
module cmpflag_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);

  // No reset on the array so it maps onto distributed RAM.
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous reads: a same-cycle write is not yet visible.
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/cmpflag_int.sv
module cmpflag_int
  import cmpflag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output nzcv_t        flags
);

  logic [W-1:0] diff;
  logic a_neg, b_neg, r_neg;

  assign diff  = a - b;
  assign a_neg = a[W-1];
  assign b_neg = b[W-1];
  assign r_neg = diff[W-1];

  always_comb begin
    flags.n = r_neg;
    flags.z = (diff == '0);
    // Signed overflow: operands of opposite sign and result sign flipped from a.
    flags.v = (a_neg & ~b_neg & ~r_neg) | (~a_neg & b_neg & r_neg);
    // No-borrow carry from the operand and result sign bits.
    flags.c = (a_neg & ~b_neg) | (a_neg & ~r_neg) | (~b_neg & ~r_neg);
  end

endmodule

// File: rtl/cmpflag_flt.sv
module cmpflag_flt
  import cmpflag_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FW = 1 + EXP_W + MAN_W
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output nzcv_t         flags
);

  logic          a_sgn, b_sgn;
  logic [FW-2:0] a_mag, b_mag;
  logic          a_nan, b_nan, both_zero;
  logic          mag_lt, mag_gt, eq, lt, gt;

  assign a_sgn = a[FW-1];
  assign b_sgn = b[FW-1];
  assign a_mag = a[FW-2:0];
  assign b_mag = b[FW-2:0];

  assign a_nan = (&a[FW-2:MAN_W]) & (|a[MAN_W-1:0]);
  assign b_nan = (&b[FW-2:MAN_W]) & (|b[MAN_W-1:0]);
  assign both_zero = (a_mag == '0) && (b_mag == '0);

  // Exponent above mantissa makes the magnitude field order like an integer.
  assign mag_lt = a_mag < b_mag;
  assign mag_gt = a_mag > b_mag;

  always_comb begin
    eq = (a == b) | both_zero;
    if (a_sgn != b_sgn) begin
      lt = a_sgn & ~both_zero;
      gt = b_sgn & ~both_zero;
    end else if (!a_sgn) begin
      lt = mag_lt;
      gt = mag_gt;
    end else begin
      lt = mag_gt;
      gt = mag_lt;
    end
  end

  always_comb begin
    if (a_nan | b_nan) begin
      flags = '0;
    end else begin
      flags.n = lt;
      flags.z = eq;
      flags.c = gt;
      flags.v = 1'b0;
    end
  end

endmodule

// File: rtl/cmpflag_top.sv
module cmpflag_top
  import cmpflag_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int REG_W     = 64,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int HALF_W   = REG_W / 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [REG_W-1:0]       wr_data,
  input  logic                   cmp_valid,
  input  logic [1:0]             cmp_mode,
  input  logic [IDX_W-1:0]       idx_a,
  input  logic [IDX_W-1:0]       idx_b,
  output logic                   res_valid,
  output logic [FLAG_WORD_W-1:0] res_flags
);

  logic [REG_W-1:0] opa, opb;
  nzcv_t f_i32, f_i64, f_flt, f_sel;

  cmpflag_regfile #(
    .DEPTH (REG_COUNT),
    .WIDTH (REG_W)
  ) u_rf (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_idx),
    .wdata   (wr_data),
    .raddr_a (idx_a),
    .rdata_a (opa),
    .raddr_b (idx_b),
    .rdata_b (opb)
  );

  // Narrow integer compare on the lower halves.
  cmpflag_int #(.W(HALF_W)) u_i32 (
    .a     (opa[HALF_W-1:0]),
    .b     (opb[HALF_W-1:0]),
    .flags (f_i32)
  );

  // Wide integer compare on the whole registers.
  cmpflag_int #(.W(REG_W)) u_i64 (
    .a     (opa),
    .b     (opb),
    .flags (f_i64)
  );

  // Single-precision compare on the upper halves.
  cmpflag_flt u_flt (
    .a     (opa[REG_W-1:HALF_W]),
    .b     (opb[REG_W-1:HALF_W]),
    .flags (f_flt)
  );

  always_comb begin
    case (cmp_mode_e'(cmp_mode))
      MODE_I32: f_sel = f_i32;
      MODE_I64: f_sel = f_i64;
      MODE_F32: f_sel = f_flt;
      default:  f_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_flags <= '0;
    end else begin
      res_valid <= cmp_valid;
      if (cmp_valid) res_flags <= pack_flags(f_sel);
    end
  end

endmodule

// File: rtl/cmpflag_chk.sv
module cmpflag_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_valid,
  input logic [1:0]       cmp_mode,
  input logic [IDX_W-1:0] idx_a,
  input logic [IDX_W-1:0] idx_b,
  input logic             res_valid,
  input logic [31:0]      res_flags
);

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_flags[27:0] == 28'd0);

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> res_valid);

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> (!res_valid && $stable(res_flags)));

  // R3
  nz_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !(res_flags[31] && res_flags[30]));

  // R6
  zero_implies_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_mode[1]) |=> (!res_flags[30] || res_flags[29]));

  // R2
  same_index_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_mode[1] && idx_a == idx_b) |=> (res_flags[31:28] == 4'b0110));

  // R7
  float_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_mode == 2'd2) |=>
      (!res_flags[28] && $countones(res_flags[31:29]) <= 1));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_mode == 2'd3) |=> (res_flags == 32'd0));

endmodule

bind cmpflag_top cmpflag_chk u_chk (.*);

// File: tb/tb_cmpflag_top.sv
`timescale 1ns/1ps
module tb_cmpflag_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_mode = '0;
  logic [3:0]  idx_a = '0;
  logic [3:0]  idx_b = '0;
  logic        res_valid;
  logic [31:0] res_flags;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [63:0] model_rf [16];
  logic        exp_valid = 1'b0;
  logic [31:0] exp_flags = '0;

  always #2.5 clk = ~clk;

  cmpflag_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cmp_valid(cmp_valid), .cmp_mode(cmp_mode), .idx_a(idx_a), .idx_b(idx_b),
    .res_valid(res_valid), .res_flags(res_flags)
  );

  function automatic real f32_value(input logic [31:0] f);
    real mag;
    int  e;
    e = int'(f[30:23]);
    if (e == 255)      mag = 1.0e300;
    else if (e == 0)   mag = real'(f[22:0]) * (2.0 ** (-149));
    else               mag = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return f[31] ? -mag : mag;
  endfunction

  function automatic logic [31:0] ref_word(input logic [1:0] md,
                                           input logic [63:0] a, input logic [63:0] b);
    logic n, z, c, v;
    logic signed [65:0] d;
    real ra, rb;
    n = 0; z = 0; c = 0; v = 0;
    if (md == 2'd0) begin
      d = $signed({{34{a[31]}}, a[31:0]}) - $signed({{34{b[31]}}, b[31:0]});
      v = (d > 66'sd2147483647) || (d < -66'sd2147483648);
      n = v ? (d > 0) : (d < 0);
      z = (a[31:0] == b[31:0]);
      c = (a[31:0] >= b[31:0]);
    end else if (md == 2'd1) begin
      d = $signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b});
      v = (d > $signed({3'b000, {63{1'b1}}})) || (d < $signed({3'b111, 63'd0}));
      n = v ? (d > 0) : (d < 0);
      z = (a == b);
      c = (a >= b);
    end else if (md == 2'd2) begin
      if (!((&a[62:55]) && (|a[54:32])) && !((&b[62:55]) && (|b[54:32]))) begin
        ra = f32_value(a[63:32]);
        rb = f32_value(b[63:32]);
        z = (ra == rb);
        n = (ra < rb);
        c = (ra > rb);
      end
    end
    return {n, z, c, v, 28'd0};
  endfunction

  string cur_tag;

  task automatic check_now();
    compared++;
    if (res_valid !== exp_valid || res_flags !== exp_flags) begin
      mismatched++;
      $display("FAIL %s: got valid=%b flags=%h, expected valid=%b flags=%h",
               cur_tag, res_valid, res_flags, exp_valid, exp_flags);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] wi, input logic [63:0] wd,
                      input logic cv, input logic [1:0] md,
                      input logic [3:0] ia, input logic [3:0] ib, input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    cmp_valid = cv; cmp_mode = md; idx_a = ia; idx_b = ib;
    // Model resolves the compare before applying the write (R12).
    exp_valid = cv;
    if (cv) exp_flags = ref_word(md, model_rf[ia], model_rf[ib]);
    if (we) model_rf[wi] = wd;
    cur_tag = tag;
    @(posedge clk);
    #1;
    check_now();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  function automatic logic [31:0] pick_half();
    logic [31:0] pool [10];
    pool = '{32'h0, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h3F800000,
             32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'h00000001, 32'hBF800000};
    if ($urandom_range(1, 0) == 0) return pool[$urandom_range(9, 0)];
    return $urandom();
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got no completion, expected completion before timeout");
      report();
      $finish;
    end
  end

  initial begin
    // R13: reset holds outputs at zero even with a request present.
    cmp_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cur_tag = "R13 reset";
    exp_valid = 0; exp_flags = 0;
    check_now();
    @(negedge clk);
    rst = 1'b0; cmp_valid = 1'b0;

    model_rf[0]  = 64'h0;
    model_rf[1]  = {32'h3F800000, 32'h00000005};
    model_rf[2]  = {32'h40000000, 32'hFFFFFFFB};
    model_rf[3]  = {32'hBF800000, 32'h80000000};
    model_rf[4]  = {32'h80000000, 32'h7FFFFFFF};
    model_rf[5]  = {32'h7FC00000, 32'h00000001};
    model_rf[6]  = {32'h7F800000, 32'h00000002};
    model_rf[7]  = {32'hFF800000, 32'h00000003};
    model_rf[8]  = 64'h8000000000000000;
    model_rf[9]  = 64'h7FFFFFFFFFFFFFFF;
    model_rf[10] = 64'h0000000100000000;
    model_rf[11] = 64'h00000000FFFFFFFF;
    for (int i = 12; i < 16; i++) model_rf[i] = {$urandom(), $urandom()};
    for (int i = 0; i < 16; i++) step(1, 4'(i), model_rf[i], 0, 0, 0, 0, "R12 load");

    step(0, 0, 0, 1, 0, 1, 2,  "R3 int32 5 vs -5");
    step(0, 0, 0, 1, 0, 2, 1,  "R6 int32 -5 vs 5");
    step(0, 0, 0, 1, 0, 3, 4,  "R5 int32 min minus max");
    step(0, 0, 0, 1, 0, 4, 3,  "R5 int32 max minus min");
    step(0, 0, 0, 1, 0, 1, 1,  "R2 same register int32");
    step(0, 0, 0, 1, 1, 9, 9,  "R2 same register int64");
    step(0, 0, 0, 1, 1, 8, 9,  "R4 int64 min minus max");
    step(0, 0, 0, 1, 1, 10, 11, "R4 int64 upper half matters");
    step(0, 0, 0, 1, 0, 10, 11, "R3 int32 lower half only");
    step(0, 0, 0, 1, 2, 1, 2,  "R7 float 1.0 vs 2.0");
    step(0, 0, 0, 1, 2, 2, 1,  "R7 float 2.0 vs 1.0");
    step(0, 0, 0, 1, 2, 3, 1,  "R7 float -1.0 vs 1.0");
    step(0, 0, 0, 1, 2, 0, 4,  "R8 float +0 vs -0");
    step(0, 0, 0, 1, 2, 7, 6,  "R8 float -inf vs +inf");
    step(0, 0, 0, 1, 2, 6, 2,  "R8 float +inf vs 2.0");
    step(0, 0, 0, 1, 2, 5, 1,  "R9 float NaN first");
    step(0, 0, 0, 1, 2, 1, 5,  "R9 float NaN second");
    step(0, 0, 0, 1, 3, 1, 2,  "R10 reserved mode");
    step(0, 0, 0, 1, 0, 2, 1,  "R11 new result");
    step(0, 0, 0, 0, 0, 0, 0,  "R11 hold");
    step(0, 0, 0, 0, 1, 3, 4,  "R11 hold ignores idle inputs");
    // R12: write to an operand in the same cycle as its compare.
    step(1, 1, 64'h0000000000000000, 1, 0, 1, 0, "R12 same-cycle old value");
    step(0, 0, 0, 1, 0, 1, 0, "R12 next-cycle new value");
    step(1, 0, 64'h40400000FFFFFFFF, 1, 2, 0, 2, "R12 same-cycle float old");
    step(0, 0, 0, 1, 2, 0, 2, "R12 next-cycle float new");

    // R13: reset mid-run clears a held result.
    @(negedge clk);
    rst = 1'b1; cmp_valid = 1'b0; wr_en = 1'b0;
    exp_valid = 0; exp_flags = 0; cur_tag = "R13 mid-run reset";
    @(posedge clk); #1; check_now();
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < 4000; k++) begin
      logic [1:0] md;
      string t;
      md = 2'($urandom_range(3, 0));
      case (md)
        2'd0: t = "R3 R5 R6 random int32";
        2'd1: t = "R4 R5 R6 random int64";
        2'd2: t = "R7 R9 random float";
        default: t = "R10 random reserved";
      endcase
      step($urandom_range(2, 0) == 0, 4'($urandom()), {pick_half(), pick_half()},
           $urandom_range(3, 0) != 0, md, 4'($urandom()), 4'($urandom()), t);
    end

    done = 1;
    report();
    $finish;
  end

endmodule